// File: doc/BRIEF.md
# Memory Chip-Enable Gating Controller

This block sits between a processor's active-low memory chip-enable and the memory device. Its job is to protect battery-backed memory from stray writes while the system supervisor holds the processor in reset. While the supervisor reset is released, the chip-enable passes straight through as combinational logic, so it adds no clock latency to the access.

When the supervisor reset asserts, an access that is already under way may finish. It gets a bounded grace window, measured in ticks of a slow timebase. The gate shuts when the processor releases the chip-enable or when the window runs out, whichever comes first. Once shut, the output is driven inactive (high) and stays there until the supervisor reset releases. The gate also stays shut through power-up and while the system runs from its backup supply.

A status output reports whether the gate is currently passing the chip-enable.

Top module: `mem_ce_gate`

## Requirements
- R1: While the gate is open and `sup_reset` is low, `ce_out_n` equals `ce_in_n` in the same cycle, with no register in the path.
- R2: If `ce_in_n` is high when `sup_reset` is first seen high, the gate shuts in that same cycle (`gate_open` = 0) and no grace window is granted.
- R3: If `ce_in_n` is low when `sup_reset` rises, `ce_out_n` stays low. It goes high in the same cycle that `ce_in_n` goes high, and that ends the grace window.
- R4: With `ce_in_n` held low after `sup_reset` rises, `ce_out_n` stays low through `GRACE_TICKS` counted ticks (default 15). Ticks count from the cycle after entry, one per clock edge with `tick` = 1. `ce_out_n` is high from the clock edge that samples the last of those ticks.
- R5: Once the gate has shut, `ce_out_n` stays high while `sup_reset` stays high, even if `ce_in_n` goes low again.
- R6: After the block's own reset `rst_n`, the gate is shut whatever `ce_in_n` does, until `sup_reset` is sampled low. It opens on the first clock edge that samples `sup_reset` low, and not before that edge.
- R7: While `batt_backup` is high, `ce_out_n` is 1 and `gate_open` is 0 whatever `ce_in_n` does. The gate stays shut afterwards while `sup_reset` remains high.
- R8: `gate_open` is 1 exactly when `ce_out_n` is following `ce_in_n`. `ce_out_n` is low only if `ce_in_n` is low and `gate_open` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the controller |
| sup_reset | input | 1 | Supervisor reset, active high |
| batt_backup | input | 1 | High while the system runs from its backup supply |
| tick | input | 1 | One-cycle timebase pulse that paces the grace window |
| ce_in_n | input | 1 | Chip-enable from the processor, active low |
| ce_out_n | output | 1 | Gated chip-enable to the memory, active low |
| gate_open | output | 1 | High while the gate passes the chip-enable |

## Verification
The bench targets the instant `sup_reset` rises. A design that registered the decision would let one extra low cycle through when the input was idle, or cut a live access short. It counts ticks one by one up to the grace limit, which exposes an off-by-one counter as a window one tick too long or too short. After closure it pulls `ce_in_n` low again, which catches a gate that reopens on the new access. It also checks the cycle right after `sup_reset` releases, where a combinational reopen or a lost power-up state would show.

// File: rtl/cegate_pkg.sv
// Shared types for the chip-enable gating controller.
// Assumes: none; pure type definitions.
package cegate_pkg;
    typedef enum logic [1:0] {
        GATE_OPEN  = 2'd0,   // chip-enable passed through
        GATE_GRACE = 2'd1,   // reset seen, in-flight access allowed to finish
        GATE_SHUT  = 2'd2    // output forced inactive
    } gate_state_e;
endpackage

// File: rtl/cegate_grace_timer.sv
// Counts timebase ticks while the grace window is running and flags the
// tick that ends it.
// Assumes: GRACE_TICKS >= 1; run drops the cycle after expire is raised.
module cegate_grace_timer #(
    parameter int GRACE_TICKS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(GRACE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(GRACE_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Tick counter, cleared whenever the window is not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Final tick of the window.
    always_comb begin
        expire = run && tick && (cnt_q == LAST);
    end
endmodule

// File: rtl/cegate_state_ctl.sv
// Gate state register: open / grace / shut, driven by the supervisor
// reset, the backup flag, the incoming chip-enable and timer expiry.
// Assumes: all inputs synchronous to clk.
module cegate_state_ctl
    import cegate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sup_reset,
    input  logic        batt_backup,
    input  logic        ce_in_n,
    input  logic        expire,
    output gate_state_e state_q
);
    gate_state_e state_d;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        if (batt_backup) begin
            state_d = GATE_SHUT;
        end else if (!sup_reset) begin
            state_d = GATE_OPEN;
        end else begin
            case (state_q)
                GATE_OPEN:  state_d = ce_in_n ? GATE_SHUT : GATE_GRACE;
                GATE_GRACE: state_d = (ce_in_n || expire) ? GATE_SHUT : GATE_GRACE;
                GATE_SHUT:  state_d = GATE_SHUT;
                default:    state_d = GATE_SHUT;
            endcase
        end
    end

    // State register; power-up starts shut.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_SHUT;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/cegate_out_path.sv
// Combinational chip-enable path: passes the input while the gate is open
// and drives the output inactive otherwise.
// Assumes: state_q comes from cegate_state_ctl.
module cegate_out_path
    import cegate_pkg::*;
(
    input  gate_state_e state_q,
    input  logic        sup_reset,
    input  logic        batt_backup,
    input  logic        ce_in_n,
    output logic        ce_out_n,
    output logic        gate_open
);
    logic pass_free;
    logic pass_grace;

    // Decide whether the path conducts this cycle.
    always_comb begin
        pass_free  = (state_q == GATE_OPEN) && !sup_reset;
        pass_grace = ((state_q == GATE_OPEN) || (state_q == GATE_GRACE))
                     && sup_reset && !ce_in_n;
        gate_open  = !batt_backup && (pass_free || pass_grace);
        ce_out_n   = gate_open ? ce_in_n : 1'b1;
    end
endmodule

// File: rtl/mem_ce_gate.sv
// Top of the memory chip-enable gating controller.
// Assumes: tick is a single-cycle pulse; GRACE_TICKS >= 1.
module mem_ce_gate
    import cegate_pkg::*;
#(
    parameter int GRACE_TICKS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_reset,
    input  logic batt_backup,
    input  logic tick,
    input  logic ce_in_n,
    output logic ce_out_n,
    output logic gate_open
);
    gate_state_e state_q;
    logic        expire;
    logic        in_grace;

    // Grace timer runs only in the grace state.
    always_comb begin
        in_grace = (state_q == GATE_GRACE);
    end

    cegate_grace_timer #(.GRACE_TICKS(GRACE_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (in_grace),
        .tick   (tick),
        .expire (expire)
    );

    cegate_state_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sup_reset   (sup_reset),
        .batt_backup (batt_backup),
        .ce_in_n     (ce_in_n),
        .expire      (expire),
        .state_q     (state_q)
    );

    cegate_out_path u_path (
        .state_q     (state_q),
        .sup_reset   (sup_reset),
        .batt_backup (batt_backup),
        .ce_in_n     (ce_in_n),
        .ce_out_n    (ce_out_n),
        .gate_open   (gate_open)
    );
endmodule

// File: rtl/cegate_checker.sv
// Port-level properties of mem_ce_gate, attached by bind.
// Assumes: observed from the top module's ports only.
module cegate_checker #(
    parameter int GRACE_TICKS = 15
) (
    input logic clk,
    input logic rst_n,
    input logic sup_reset,
    input logic batt_backup,
    input logic tick,
    input logic ce_in_n,
    input logic ce_out_n,
    input logic gate_open
);
    localparam int CW = $clog2(GRACE_TICKS + 3);

    logic [CW-1:0] low_ticks_q;

    // Ticks seen while the output is held low under supervisor reset.
    // The entry cycle may add one tick the design does not count.
    always_ff @(posedge clk) begin
        if (!rst_n || !sup_reset || ce_out_n) begin
            low_ticks_q <= '0;
        end else if (tick && (low_ticks_q != '1)) begin
            low_ticks_q <= low_ticks_q + 1'b1;
        end
    end

    assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sup_reset) && !$past(batt_backup)
         && !sup_reset && !batt_backup) |-> (ce_out_n == ce_in_n));

    assert_stay_shut_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_reset && !gate_open) |=> (!sup_reset || ce_out_n));

    assert_grace_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        low_ticks_q <= CW'(GRACE_TICKS + 1));

    assert_powerup_shut_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !gate_open);

    assert_backup_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        batt_backup |-> (ce_out_n && !gate_open));

    assert_low_needs_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_out_n |-> (!ce_in_n && gate_open));

    assert_shut_is_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |-> ce_out_n);
endmodule

bind mem_ce_gate cegate_checker #(.GRACE_TICKS(GRACE_TICKS)) u_cegate_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sup_reset   (sup_reset),
    .batt_backup (batt_backup),
    .tick        (tick),
    .ce_in_n     (ce_in_n),
    .ce_out_n    (ce_out_n),
    .gate_open   (gate_open)
);

// File: tb/test_mem_ce_gate.sv
module test_mem_ce_gate;
    localparam int GT = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_reset = 1'b1;
    logic batt_backup = 1'b0;
    logic tick = 1'b0;
    logic ce_in_n = 1'b1;
    logic ce_out_n;
    logic gate_open;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    mem_ce_gate #(.GRACE_TICKS(GT)) i_mem_ce_gate (
        .clk(clk), .rst_n(rst_n), .sup_reset(sup_reset),
        .batt_backup(batt_backup), .tick(tick), .ce_in_n(ce_in_n),
        .ce_out_n(ce_out_n), .gate_open(gate_open)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Inputs change on the falling edge; sample 2 ns later.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic t_reset_state();
        ce_in_n = 1'b0;
        repeat (3) step();
        settle();
        check("R6 reset ce_out_n", ce_out_n, 1'b1);
        check("R6 reset gate_open", gate_open, 1'b0);
    endtask

    task automatic t_powerup();
        step(); rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step(); ce_in_n = i[0]; settle();
            check("R6 powerup held shut", ce_out_n, 1'b1);
        end
        step(); ce_in_n = 1'b0; sup_reset = 1'b0; settle();
        check("R6 not open before edge", ce_out_n, 1'b1);
        step(); settle();
        check("R6 opens after edge", ce_out_n, 1'b0);
        check("R8 open status", gate_open, 1'b1);
    endtask

    task automatic t_follow();
        logic [7:0] pat = 8'b1011_0010;
        for (int i = 0; i < 8; i++) begin
            step(); ce_in_n = pat[i]; tick = i[0]; settle();
            check("R1 follows input", ce_out_n, pat[i]);
            check("R8 open while following", gate_open, 1'b1);
        end
        tick = 1'b0;
    endtask

    task automatic t_reset_idle();
        step(); ce_in_n = 1'b1; sup_reset = 1'b1; settle();
        check("R2 shut same cycle", gate_open, 1'b0);
        step(); ce_in_n = 1'b0; settle();
        check("R5 no reopen", ce_out_n, 1'b1);
        step(); settle();
        check("R5 still shut", ce_out_n, 1'b1);
        sup_reset = 1'b0;
        step(); settle();
        check("R6 reopen after release", ce_out_n, 1'b0);
    endtask

    task automatic t_reset_endaccess();
        step(); ce_in_n = 1'b0; sup_reset = 1'b1; settle();
        check("R3 access continues", ce_out_n, 1'b0);
        check("R8 grace status", gate_open, 1'b1);
        for (int i = 0; i < 5; i++) begin
            step(); tick = 1'b1; step(); tick = 1'b0; settle();
            check("R3 low during grace", ce_out_n, 1'b0);
        end
        step(); ce_in_n = 1'b1; settle();
        check("R3 ends on input high", ce_out_n, 1'b1);
        step(); ce_in_n = 1'b0; settle();
        check("R5 new access blocked", ce_out_n, 1'b1);
        check("R8 shut status", gate_open, 1'b0);
        step(); sup_reset = 1'b0; ce_in_n = 1'b1;
        step(); settle();
        check("R1 reopened", gate_open, 1'b1);
    endtask

    task automatic t_grace_expire();
        step(); ce_in_n = 1'b0; sup_reset = 1'b1;
        for (int i = 1; i <= GT; i++) begin
            step(); tick = 1'b1;
            step(); tick = 1'b0; settle();
            check("R4 grace window", ce_out_n, (i < GT) ? 1'b0 : 1'b1);
        end
        step(); step(); settle();
        check("R5 stays shut after expiry", ce_out_n, 1'b1);
        sup_reset = 1'b0;
        step(); settle();
        check("R1 open after expiry release", ce_out_n, 1'b0);
    endtask

    task automatic t_battery();
        step(); sup_reset = 1'b1; ce_in_n = 1'b1;
        step(); batt_backup = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step(); ce_in_n = i[0]; settle();
            check("R7 backup out high", ce_out_n, 1'b1);
            check("R7 backup status", gate_open, 1'b0);
        end
        step(); batt_backup = 1'b0; ce_in_n = 1'b0;
        step(); settle();
        check("R7 shut after backup", ce_out_n, 1'b1);
        sup_reset = 1'b0;
        step(); settle();
        check("R6 reopen after backup", ce_out_n, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset_state();
        t_powerup();
        t_follow();
        t_reset_idle();
        t_reset_endaccess();
        t_grace_expire();
        t_battery();
        finish_run();
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end
endmodule